// File: doc/BRIEF.md
# Prescaled Interval Timer with Interrupt

This block is an 8-bit interval timer for a processor bus. A write loads a count. The low address bits of that same write pick how many clocks make up one interval: 1, 8, 64 or 1024. The count then drops by one per interval. A read taken before expiry shows how many intervals are still left. After the interval that follows a count of zero, an interrupt flag is set and the counter wraps to 255.

From then on the counter drops once per clock, with no prescaling. A read therefore shows how long ago the flag was set, as 255 minus the count. The counter stops at zero, which stands for 255 clocks past expiry.

Every timer access, read or write, uses address bit 3 to decide whether the flag drives the active-low interrupt pin. Address bit 2 must be 1 for an access to reach the timer.

Top module: `interval_timer`

## Requirements
- R1: A timer write (sel_i=1, wr_i=1, addr_i[2]=1) loads wdata_i into the count and clears the flag. A count read (addr_i[0]=0) returns the loaded value right after the write edge.
- R2: On a timer write, addr_i[1:0] sets the interval length: 0 gives 1 clock, 1 gives 8, 2 gives 64 and 3 gives 1024. The write also restarts the interval from its first clock.
- R3: Before expiry, the count falls by one at the end of each full interval. A count of N therefore sets the flag exactly (N+1) intervals after the write edge.
- R4: At expiry the flag becomes 1 and the count becomes 255. After that the count falls by one on every clock, whatever interval length was chosen.
- R5: Once the flag is set, the count holds at 0 and does not wrap again.
- R6: The flag stays set until the next timer write. Reads do not clear it.
- R7: Every timer access (write or read with sel_i=1 and addr_i[2]=1) copies addr_i[3] into the interrupt enable. irq_no is 0 exactly when both the flag and the enable are 1.
- R8: When addr_i[0]=1, rdata_o returns the flag in bit 7 and zeros in bits 6:0. When addr_i[0]=0, rdata_o returns the count.
- R9: Reset gives count 0, flag 0, interrupt disabled and the 1-clock interval, so irq_no is 1.
- R10: An access with sel_i=0 or addr_i[2]=0 changes neither the count, the flag nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Block select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Bits 1:0 interval choice, bit 2 timer decode, bit 3 interrupt enable, bit 0 read select |
| wdata_i | input | 8 | Count to load |
| rdata_o | output | 8 | Count or status |
| irq_no | output | 1 | Interrupt, active low |

## Verification
If the prescaler phase or the interval choice goes wrong, the first decrement moves off by one or more clocks. A reference model compared on every clock reports that error within one interval of the write. A wrong flag or a missed switch to per-clock counting shows on the status bit and on irq_no in the cycle of expiry. From the next clock the count also falls at the wrong rate. A lost enable bit shows on irq_no in the cycle after the access that set it.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned PRE_W = 10;

  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_8    = 2'd1,
    DIV_64   = 2'd2,
    DIV_1024 = 2'd3
  } presc_e;

  function automatic logic [PRE_W-1:0] presc_last(presc_e s);
    case (s)
      DIV_1:   presc_last = PRE_W'(0);
      DIV_8:   presc_last = PRE_W'(7);
      DIV_64:  presc_last = PRE_W'(63);
      default: presc_last = PRE_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
  import itmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] div_sel_i,
  input  logic       fast_i,
  output logic       tick_o
);
  presc_e           sel_q;
  logic [PRE_W-1:0] phase_q;
  logic             last;

  assign last   = (phase_q == presc_last(sel_q));
  assign tick_o = fast_i | last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= DIV_1;
      phase_q <= '0;
    end else if (restart_i) begin
      sel_q   <= presc_e'(div_sel_i);
      phase_q <= '0;
    end else if (last || fast_i) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      flag_q <= 1'b0;
    end else if (tick_i) begin
      if (!flag_q) begin
        if (at_zero) begin
          cnt_q  <= '1;   // expiry: wrap to full scale
          flag_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (!at_zero) begin
        cnt_q <= cnt_q - 1'b1; // overrun measure, saturates at 0
      end
    end
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [3:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_no
);
  logic             hit, wr_hit, acc_hit;
  logic             tick;
  logic             flag;
  logic [CNT_W-1:0] count;
  logic             irq_en_q;

  assign hit     = sel_i & addr_i[2];
  assign wr_hit  = hit & wr_i;
  assign acc_hit = hit & (wr_i | rd_i);

  itmr_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_hit),
    .div_sel_i (addr_i[1:0]),
    .fast_i    (flag),
    .tick_o    (tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_hit),
    .load_val_i (wdata_i),
    .tick_i     (tick),
    .count_o    (count),
    .flag_o     (flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_en_q <= 1'b0;
    else if (acc_hit) irq_en_q <= addr_i[3];
  end

  assign rdata_o = addr_i[0] ? {flag, {(CNT_W-1){1'b0}}} : count;
  assign irq_no  = ~(flag & irq_en_q);
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [3:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             irq_no
);
  logic wr_hit, acc_hit;
  assign wr_hit  = sel_i & addr_i[2] & wr_i;
  assign acc_hit = sel_i & addr_i[2] & (wr_i | rd_i);

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (count == $past(wdata_i)) && !flag); // R1
  AST_EXPIRY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> count == {CNT_W{1'b1}}); // R4
  AST_FAST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && count != '0 && !wr_hit) |=> count == $past(count) - 1'b1); // R4
  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && count == '0 && !wr_hit) |=> count == '0); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !wr_hit) |=> flag); // R6
  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_hit && !addr_i[3]) |=> irq_no); // R7
  AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && acc_hit && addr_i[3] && flag) |=> !irq_no); // R7
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hit && !flag && count != '0) |=> (count == $past(count)) || (count == $past(count) - 1'b1)); // R10
endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .count   (count),
  .flag    (flag),
  .irq_no  (irq_no)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 60000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0] addr_i = 4'h0;
  logic [7:0] wdata_i = 8'h0;
  logic [7:0] rdata_o;
  logic       irq_no;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R9";

  int m_count = 0, m_div = 1, m_phase = 0;
  bit m_flag = 0, m_en = 0;

  interval_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    return addr_i[0] ? (m_flag ? 128 : 0) : m_count;
  endfunction

  // reference model, compared a quarter period after each edge
  always @(posedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      m_count = 0; m_flag = 0; m_en = 0; m_div = 1; m_phase = 0;
    end else begin
      if (sel_i && addr_i[2] && (wr_i || rd_i)) m_en = addr_i[3];
      if (sel_i && addr_i[2] && wr_i) begin
        m_count = wdata_i; m_flag = 0; m_phase = 0;
        case (addr_i[1:0])
          2'd0: m_div = 1;
          2'd1: m_div = 8;
          2'd2: m_div = 64;
          default: m_div = 1024;
        endcase
      end else if (!m_flag) begin
        m_phase++;
        if (m_phase == m_div) begin
          m_phase = 0;
          if (m_count == 0) begin m_count = 255; m_flag = 1; end
          else m_count--;
        end
      end else if (m_count > 0) begin
        m_count--;
      end
    end
    #(CLK_PERIOD/4);
    chk({cur_req, " rdata"}, rdata_o, exp_rdata());
    chk({cur_req, " irq_no"}, irq_no, (m_flag && m_en) ? 0 : 1);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0; addr_i = 4'h0;
  endtask

  task automatic do_read(input logic [3:0] a);
    sel_i = 1; rd_i = 1; addr_i = a;
    @(negedge clk_i);
    sel_i = 0; rd_i = 0; addr_i = 4'h0;
  endtask

  initial begin
    #1;
    chk("R9 count", rdata_o, 0);
    chk("R9 irq_no", irq_no, 1);
    idle(2);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 / R3: load 52, 1-clock interval, interrupt enabled
    cur_req = "R3";
    do_write(4'b1100, 8'b0011_0100);
    chk("R1 load", rdata_o, 52);
    idle(1);
    chk("R3 remaining", rdata_o, 51);
    idle(1);
    chk("R3 remaining", rdata_o, 50);
    idle(49);
    chk("R3 last", rdata_o, 1);
    idle(1);
    chk("R3 zero", rdata_o, 0);
    idle(1);
    cur_req = "R4";
    chk("R4 wrap", rdata_o, 255);
    chk("R7 irq low", irq_no, 0);
    idle(10);
    chk("R4 per clock", rdata_o, 245);
    addr_i = 4'h1; #1;
    chk("R8 status", rdata_o, 128);
    addr_i = 4'h0;

    // R5 saturation
    cur_req = "R5";
    idle(300);
    chk("R5 saturate", rdata_o, 0);

    // R6 / R7: read with enable low keeps flag, releases irq
    cur_req = "R6";
    do_read(4'b0101);
    chk("R7 disabled", irq_no, 1);
    addr_i = 4'h1; #1;
    chk("R6 flag kept", rdata_o, 128);
    addr_i = 4'h0;
    do_read(4'b1101);
    chk("R7 re-enabled", irq_no, 0);

    // R10: ignored accesses
    cur_req = "R10";
    sel_i = 0; wr_i = 1; addr_i = 4'b0100; wdata_i = 8'd9;
    @(negedge clk_i);
    sel_i = 1; addr_i = 4'b0000;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0;
    chk("R10 count kept", rdata_o, 0);
    chk("R10 irq kept", irq_no, 0);

    // R2: 8-clock interval
    cur_req = "R2";
    do_write(4'b0101, 8'd3);
    idle(7);
    chk("R2 div8 hold", rdata_o, 3);
    idle(1);
    chk("R2 div8 step", rdata_o, 2);
    // restart mid-interval
    idle(4);
    do_write(4'b0101, 8'd3);
    idle(7);
    chk("R2 restart hold", rdata_o, 3);
    idle(1);
    chk("R2 restart step", rdata_o, 2);
    idle(30);
    addr_i = 4'h1; #1;
    chk("R3 div8 expiry", rdata_o, 128);
    addr_i = 4'h0;

    // R2: 64 and 1024 intervals
    do_write(4'b0110, 8'd1);
    idle(63);
    chk("R2 div64 hold", rdata_o, 1);
    idle(1);
    chk("R2 div64 step", rdata_o, 0);
    idle(64);
    chk("R4 div64 wrap", rdata_o, 255);
    do_write(4'b1111, 8'd1);
    idle(1023);
    chk("R2 div1024 hold", rdata_o, 1);
    idle(1);
    chk("R2 div1024 step", rdata_o, 0);
    idle(1024);
    chk("R4 div1024 wrap", rdata_o, 255);
    chk("R7 irq div1024", irq_no, 0);
    do_write(4'b0100, 8'd0);
    chk("R1 clear flag", irq_no, 1);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > WDOG_CYC);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WDOG_CYC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule